// File: doc/BRIEF.md
# Scanline Producer with Frame-Committed Descriptor Pointer

This block is the upstream stage of a display pipe. It generates scanlines into a small line buffer, and a downstream timing sequencer drains that buffer. Each line is represented here only by its line number, which serves as a tag. The producer can fill far faster than the consumer drains. It therefore fills the buffer as soon as a frame begins, stalls while the buffer is full, and then advances one line for every line removed. Once the last active line of the frame has been generated, it stops and the consumer empties what remains. A status output reports the line the producer is currently generating. Because of the buffering, that value runs ahead of the line actually being displayed by the buffer occupancy.

The block also holds a double-buffered frame descriptor pointer. Software writes a pending value at any time. The pending value is copied into the active register only on a frame-start strobe or an init strobe. Both values are visible, so software can detect that a new pointer has taken effect by comparing them. The init strobe also discards any buffered lines. The buffer capacity is derived from the horizontal active width: 14336 divided by the width, minus one. The default width of 1024 gives 13 lines.

Top module: `lp_line_producer`

## Requirements
- R1: A pointer write (`ptr_wr_en_i` high) loads `ptr_wr_data_i` into `ptr_pending_o`, where it is visible after the next clock edge.
- R2: `ptr_active_o` changes only on an edge where `frame_start_i` or `init_i` is high. On that edge it takes the pending value held before that edge, so a write in the same cycle lands only in the pending register.
- R3: After a write and before a commit, `ptr_pending_o` and `ptr_active_o` show different values and are readable independently.
- R4: A frame-start or init strobe sets `gen_line_o` to 0. It then rises by one for each line pushed and stops at `active_lines_i`. That input is held stable during a frame.
- R5: While a frame is running and lines remain, one line is pushed per cycle whenever the buffer holds fewer than its capacity, counting occupancy before any pop in the same cycle. Once the buffer is full, the producer stalls.
- R6: The capacity is 14336/H_ACTIVE − 1 (13 by default). `fifo_level_o` never exceeds it, and `fifo_full_o` is high exactly at that level.
- R7: Lines leave in push order. `pop_tag_o` shows the oldest line number whenever `fifo_empty_o` is low, and `fifo_empty_o` is high exactly when the level is 0.
- R8: A pop while the buffer is empty leaves the level unchanged and sets `underflow_o`, which stays high until reset.
- R9: An init strobe empties the buffer on its edge. A frame-start strobe keeps the buffered lines.
- R10: After reset, with both pointers 0, no line is produced until the first frame-start or init strobe.
- R11: After the last active line is generated, the producer stays idle while the consumer drains the buffer to empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame-start strobe: commits the pointer and restarts line generation |
| init_i | input | 1 | Init strobe: commits the pointer, restarts generation and flushes the buffer |
| ptr_wr_en_i | input | 1 | Pending pointer write enable |
| ptr_wr_data_i | input | PTR_W | Pointer value to write |
| ptr_pending_o | output | PTR_W | Pending pointer readback |
| ptr_active_o | output | PTR_W | Active pointer readback |
| active_lines_i | input | 12 | Number of active lines per frame |
| pop_i | input | 1 | Consumer removes the oldest line |
| pop_tag_o | output | 12 | Line number at the head of the buffer |
| gen_line_o | output | 12 | Line number currently being generated |
| fifo_level_o | output | LVL_W | Buffer occupancy in lines |
| fifo_full_o | output | 1 | Buffer at capacity |
| fifo_empty_o | output | 1 | Buffer holds no lines |
| underflow_o | output | 1 | Sticky flag: a pop arrived while the buffer was empty |

## Verification
Every result of this block is registered once. A pointer write, a commit strobe, a push, a pop or a flush each shows up at the ports on the edge that samples the stimulus. That includes the same-edge increment of `gen_line_o` and the setting of `underflow_o`. The head tag follows the registered read pointer with no additional delay. The bench drives inputs just after a falling edge, and its reference model steps on the same rising edge as the design. All ports are compared at the next falling edge, one edge after the stimulus. Directed checks sample at that same point, after a counted number of edges.

// File: rtl/lp_pkg.sv
package lp_pkg;

    // Width of the line counter and of every line tag.
    localparam int LINE_W     = 12;
    // Line buffer budget in pixels.
    localparam int BUF_PIXELS = 2048 * 7;

    typedef logic [LINE_W-1:0] line_tag_t;

    // Producer sequencing.
    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,   // out of reset, waiting for the first strobe
        GEN_FILL = 2'd1,   // generating lines of the current frame
        GEN_DONE = 2'd2    // last active line generated
    } gen_state_e;

    // Strobes decoded once at the top and shared by the sub-blocks.
    typedef struct packed {
        logic commit;   // copy pending pointer to active
        logic restart;  // line counter back to zero, start filling
        logic flush;    // discard buffered lines
    } frame_ctl_t;

    // Buffer capacity in lines for a given horizontal active width.
    function automatic int line_capacity(input int h_active);
        int cap;
        cap = BUF_PIXELS / h_active - 1;
        if (cap < 1) cap = 1;
        return cap;
    endfunction

endpackage

// File: rtl/lp_ptr_bank.sv
module lp_ptr_bank #(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_data,
    output logic [PTR_W-1:0] pending_o,
    output logic [PTR_W-1:0] active_o
);

    logic [PTR_W-1:0] pending_q;
    logic [PTR_W-1:0] active_q;

    // The commit reads the pending value held before this edge.
    // A write in the same cycle lands in the pending register only.
    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            if (commit) active_q  <= pending_q;
            if (wr_en)  pending_q <= wr_data;
        end
    end

    assign pending_o = pending_q;
    assign active_o  = active_q;

endmodule

// File: rtl/lp_line_gen.sv
module lp_line_gen
    import lp_pkg::*;
#(
    parameter int CAP   = 13,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  line_tag_t        active_lines,
    input  logic [LVL_W-1:0] level,
    output logic             push_o,
    output line_tag_t        tag_o,
    output line_tag_t        line_o
);

    localparam logic [LVL_W-1:0] CAP_LVL = LVL_W'(CAP);

    gen_state_e         state_q;
    line_tag_t          cnt_q;
    logic [LINE_W:0]    cnt_next;
    logic               lines_left;
    logic               room;

    assign lines_left = (cnt_q < active_lines);
    // Occupancy before any same-cycle pop decides whether there is room.
    assign room       = (level < CAP_LVL);
    assign cnt_next   = {1'b0, cnt_q} + 1'b1;
    assign push_o     = (state_q == GEN_FILL) && !restart && lines_left && room;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            cnt_q   <= '0;
        end else if (restart) begin
            state_q <= GEN_FILL;
            cnt_q   <= '0;
        end else if (state_q == GEN_FILL) begin
            if (push_o) cnt_q <= cnt_next[LINE_W-1:0];
            if (!lines_left || (push_o && cnt_next == {1'b0, active_lines}))
                state_q <= GEN_DONE;
        end
    end

    assign tag_o  = cnt_q;
    assign line_o = cnt_q;

endmodule

// File: rtl/lp_line_fifo.sv
module lp_line_fifo #(
    parameter int CAP   = 13,
    parameter int W     = 12,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     pop_data,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o,
    output logic             underflow_o
);

    localparam int             AW      = (CAP > 1) ? $clog2(CAP) : 1;
    localparam logic [AW-1:0]  LAST    = AW'(CAP - 1);
    localparam logic [LVL_W-1:0] CAP_LVL = LVL_W'(CAP);

    logic [W-1:0]     slot [CAP];
    logic [AW-1:0]    wr_ptr_q;
    logic [AW-1:0]    rd_ptr_q;
    logic [LVL_W-1:0] level_q;
    logic             uflow_q;
    logic             do_push;
    logic             do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty_o = (level_q == '0);
    assign full_o  = (level_q == CAP_LVL);
    assign do_push = push && !full_o && !flush;
    assign do_pop  = pop && !empty_o && !flush;

    // One storage register per line slot.
    for (genvar g = 0; g < CAP; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && wr_ptr_q == AW'(g)) slot[g] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
            uflow_q  <= 1'b0;
        end else begin
            if (pop && empty_o) uflow_q <= 1'b1;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
                level_q  <= '0;
            end else begin
                if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
                if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
                case ({do_push, do_pop})
                    2'b10:   level_q <= level_q + 1'b1;
                    2'b01:   level_q <= level_q - 1'b1;
                    default: level_q <= level_q;
                endcase
            end
        end
    end

    assign pop_data    = slot[rd_ptr_q];
    assign level_o     = level_q;
    assign underflow_o = uflow_q;

endmodule

// File: rtl/lp_line_producer.sv
module lp_line_producer
    import lp_pkg::*;
#(
    parameter int H_ACTIVE = 1024,
    parameter int PTR_W    = 32,
    parameter int CAP      = lp_pkg::line_capacity(H_ACTIVE),
    parameter int LVL_W    = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start_i,
    input  logic             init_i,
    input  logic             ptr_wr_en_i,
    input  logic [PTR_W-1:0] ptr_wr_data_i,
    output logic [PTR_W-1:0] ptr_pending_o,
    output logic [PTR_W-1:0] ptr_active_o,
    input  logic [11:0]      active_lines_i,
    input  logic             pop_i,
    output logic [11:0]      pop_tag_o,
    output logic [11:0]      gen_line_o,
    output logic [LVL_W-1:0] fifo_level_o,
    output logic             fifo_full_o,
    output logic             fifo_empty_o,
    output logic             underflow_o
);

    frame_ctl_t ctl;
    logic       push;
    line_tag_t  push_tag;

    always_comb begin
        ctl.commit  = frame_start_i | init_i;
        ctl.restart = frame_start_i | init_i;
        ctl.flush   = init_i;
    end

    lp_ptr_bank #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .commit    (ctl.commit),
        .wr_en     (ptr_wr_en_i),
        .wr_data   (ptr_wr_data_i),
        .pending_o (ptr_pending_o),
        .active_o  (ptr_active_o)
    );

    lp_line_gen #(.CAP(CAP), .LVL_W(LVL_W)) u_gen (
        .clk          (clk),
        .rst          (rst),
        .restart      (ctl.restart),
        .active_lines (active_lines_i),
        .level        (fifo_level_o),
        .push_o       (push),
        .tag_o        (push_tag),
        .line_o       (gen_line_o)
    );

    lp_line_fifo #(.CAP(CAP), .W(LINE_W), .LVL_W(LVL_W)) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .flush       (ctl.flush),
        .push        (push),
        .push_data   (push_tag),
        .pop         (pop_i),
        .pop_data    (pop_tag_o),
        .level_o     (fifo_level_o),
        .full_o      (fifo_full_o),
        .empty_o     (fifo_empty_o),
        .underflow_o (underflow_o)
    );

endmodule

// File: rtl/lp_line_producer_chk.sv
module lp_line_producer_chk #(
    parameter int PTR_W = 32,
    parameter int CAP   = 13,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_start_i,
    input logic             init_i,
    input logic             ptr_wr_en_i,
    input logic [PTR_W-1:0] ptr_wr_data_i,
    input logic [PTR_W-1:0] ptr_pending_o,
    input logic [PTR_W-1:0] ptr_active_o,
    input logic             pop_i,
    input logic [11:0]      gen_line_o,
    input logic [LVL_W-1:0] fifo_level_o,
    input logic             fifo_full_o,
    input logic             fifo_empty_o,
    input logic             underflow_o
);

    // R1
    pending_load_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_wr_en_i |=> ptr_pending_o == $past(ptr_wr_data_i));

    // R2
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(frame_start_i || init_i) |=> $stable(ptr_active_o));

    // R2
    active_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start_i || init_i) |=> ptr_active_o == $past(ptr_pending_o));

    // R4
    line_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start_i || init_i) |=> gen_line_o == 12'd0);

    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_full_o && !pop_i && !init_i) |=> fifo_full_o);

    // R6
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(fifo_level_o) <= CAP);

    // R7
    empty_level_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_empty_o |-> fifo_level_o == '0);

    // R8
    underflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && fifo_empty_o) |=> underflow_o);

    // R8
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> underflow_o);

    // R9
    init_flush_chk: assert property (@(posedge clk) disable iff (rst)
        init_i |=> fifo_empty_o);

endmodule

bind lp_line_producer lp_line_producer_chk #(
    .PTR_W (PTR_W),
    .CAP   (CAP),
    .LVL_W (LVL_W)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .frame_start_i (frame_start_i),
    .init_i        (init_i),
    .ptr_wr_en_i   (ptr_wr_en_i),
    .ptr_wr_data_i (ptr_wr_data_i),
    .ptr_pending_o (ptr_pending_o),
    .ptr_active_o  (ptr_active_o),
    .pop_i         (pop_i),
    .gen_line_o    (gen_line_o),
    .fifo_level_o  (fifo_level_o),
    .fifo_full_o   (fifo_full_o),
    .fifo_empty_o  (fifo_empty_o),
    .underflow_o   (underflow_o)
);

// File: tb/test_lp_line_producer.sv
`timescale 1ns/1ps
module test_lp_line_producer;

    localparam int PTR_W = 32;
    localparam int CAP   = 13;   // 14336/1024 - 1
    localparam int LVL_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_start_i = 1'b0;
    logic             init_i = 1'b0;
    logic             ptr_wr_en_i = 1'b0;
    logic [PTR_W-1:0] ptr_wr_data_i = '0;
    logic [PTR_W-1:0] ptr_pending_o;
    logic [PTR_W-1:0] ptr_active_o;
    logic [11:0]      active_lines_i = 12'd20;
    logic             pop_i = 1'b0;
    logic [11:0]      pop_tag_o;
    logic [11:0]      gen_line_o;
    logic [LVL_W-1:0] fifo_level_o;
    logic             fifo_full_o;
    logic             fifo_empty_o;
    logic             underflow_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lp_line_producer #(.H_ACTIVE(1024), .PTR_W(PTR_W)) i_lp_line_producer (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i), .init_i(init_i),
        .ptr_wr_en_i(ptr_wr_en_i), .ptr_wr_data_i(ptr_wr_data_i),
        .ptr_pending_o(ptr_pending_o), .ptr_active_o(ptr_active_o),
        .active_lines_i(active_lines_i), .pop_i(pop_i), .pop_tag_o(pop_tag_o),
        .gen_line_o(gen_line_o), .fifo_level_o(fifo_level_o),
        .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o),
        .underflow_o(underflow_o)
    );

    // Behavioural reference model
    int          q[$];
    int          m_gen   = 0;
    bit          m_armed = 1'b0;
    bit          m_uf    = 1'b0;
    logic [31:0] m_pend  = '0;
    logic [31:0] m_act   = '0;

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_gen = 0; m_armed = 0; m_uf = 0; m_pend = '0; m_act = '0;
        end else begin
            bit strobe, do_push, do_pop;
            strobe  = frame_start_i || init_i;
            do_push = m_armed && !strobe && (m_gen < int'(active_lines_i)) && (q.size() < CAP);
            do_pop  = pop_i && (q.size() > 0);
            if (pop_i && q.size() == 0) m_uf = 1'b1;
            if (init_i) q.delete();
            else begin
                if (do_pop)  void'(q.pop_front());
                if (do_push) q.push_back(m_gen);
            end
            if (strobe) m_act = m_pend;
            if (ptr_wr_en_i) m_pend = ptr_wr_data_i;
            if (strobe) begin m_gen = 0; m_armed = 1'b1; end
            else if (do_push) m_gen++;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, one edge after each stimulus
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 pending pointer", ptr_pending_o, m_pend);
            chk("R2 active pointer", ptr_active_o, m_act);
            chk("R4 generated line", gen_line_o, m_gen);
            chk("R5 level", fifo_level_o, q.size());
            chk("R6 full flag", fifo_full_o, q.size() == CAP);
            chk("R7 empty flag", fifo_empty_o, q.size() == 0);
            chk("R8 underflow", underflow_o, m_uf);
            if (q.size() > 0) chk("R7 head tag", pop_tag_o, q[0]);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk("R10 reset level", fifo_level_o, 0);
        chk("R10 reset empty", fifo_empty_o, 1);
        chk("R10 reset pointers", ptr_active_o | ptr_pending_o, 0);
        cyc(4);
        chk("R10 idle before strobe", fifo_level_o, 0);

        ptr_wr_en_i = 1'b1; ptr_wr_data_i = 32'hA5A5_0001;
        cyc(1);
        ptr_wr_en_i = 1'b0;
        chk("R3 pending differs", ptr_pending_o, 32'hA5A5_0001);
        chk("R3 active not yet", ptr_active_o, 0);

        frame_start_i = 1'b1;
        cyc(1);
        frame_start_i = 1'b0;
        chk("R2 commit on frame start", ptr_active_o, 32'hA5A5_0001);
        cyc(20);
        chk("R6 fills to capacity", fifo_level_o, CAP);
        chk("R5 stalls at full", gen_line_o, CAP);

        pop_i = 1'b1;
        cyc(40);
        pop_i = 1'b0;
        chk("R11 drained", fifo_empty_o, 1);
        chk("R4 stops at active count", gen_line_o, 20);
        cyc(5);
        chk("R11 idle after frame", fifo_level_o, 0);

        pop_i = 1'b1;
        cyc(1);
        pop_i = 1'b0;
        chk("R8 underflow set", underflow_o, 1);
        chk("R8 level unchanged", fifo_level_o, 0);
        cyc(3);
        chk("R8 underflow sticky", underflow_o, 1);

        ptr_wr_en_i = 1'b1; ptr_wr_data_i = 32'h0000_B00B; frame_start_i = 1'b1;
        cyc(1);
        ptr_wr_en_i = 1'b0; frame_start_i = 1'b0;
        chk("R2 same-cycle write not committed", ptr_active_o, 32'hA5A5_0001);
        chk("R2 same-cycle write pending", ptr_pending_o, 32'h0000_B00B);
        cyc(5);
        chk("R5 one line per cycle", fifo_level_o, 5);

        init_i = 1'b1;
        cyc(1);
        init_i = 1'b0;
        chk("R9 init flushes", fifo_level_o, 0);
        chk("R2 init commits", ptr_active_o, 32'h0000_B00B);
        cyc(6);
        frame_start_i = 1'b1;
        cyc(1);
        frame_start_i = 1'b0;
        chk("R9 frame start keeps lines", fifo_level_o, 6);

        pop_i = 1'b1;
        cyc(40);
        pop_i = 1'b0;
        active_lines_i = 12'd0;
        frame_start_i = 1'b1;
        cyc(1);
        frame_start_i = 1'b0;
        cyc(5);
        chk("R4 zero active lines", gen_line_o, 0);
        chk("R4 zero lines no push", fifo_level_o, 0);

        active_lines_i = 12'd3;
        frame_start_i = 1'b1;
        cyc(1);
        frame_start_i = 1'b0;
        cyc(10);
        chk("R4 short frame count", gen_line_o, 3);
        chk("R11 short frame level", fifo_level_o, 3);
        pop_i = 1'b1;
        cyc(1);
        pop_i = 1'b0;
        chk("R7 oldest tag after pop", pop_tag_o, 1);

        cyc(2);
        finish_run();
    end

endmodule